// File: doc/BRIEF.md
# Data-Processing ALU with Reverse Subtract

This block is the arithmetic and move stage of a small RISC integer datapath. Each clock it takes a first operand, a second operand that is either an immediate or the output of an external shifter, the shifter's carry-out, a 4-bit operation code and a set-flags enable. It produces a destination value, a destination write-enable and the four condition flags (negative, zero, carry, overflow). Results and flags are registered, so the outcome of an operation presented before a rising edge appears on the outputs just after that edge.

Beyond plain add and subtract, the unit computes reverse subtraction (second operand minus first) and a reverse subtract that folds in the carry flag as an inverted borrow. All adds and subtracts share one adder: the operands are swapped and one is inverted as the operation needs, and the carry-in comes from a constant or from the flag register. The carry flag the carry-using operations consume is the one held in the block's own flag register.

Top module: `dp_alu_unit`

## Requirements
- R1: Opcode 0xD (move) registers the second operand unchanged as the result with write-enable 1.
- R2: Opcode 0xF (move inverted) registers the bitwise complement of the second operand with write-enable 1.
- R3: Opcode 0x4 gives first + second; opcode 0x5 gives first + second + the registered carry flag, both modulo 2^32 with write-enable 1.
- R4: Opcode 0x2 gives first − second and opcode 0x3 gives second − first, modulo 2^32, write-enable 1.
- R5: Opcode 0x7 gives second − first − (1 − registered carry flag), modulo 2^32, write-enable 1.
- R6: When set-flags is 0, all four flags keep their values.
- R7: When flags update, N equals result bit 31 and Z is 1 exactly when all 32 result bits are 0.
- R8: On a flag update, C is the unsigned carry-out for adds, 1 when no borrow occurs for subtracts, and the shifter carry input for both move opcodes.
- R9: On a flag update, V is 1 exactly when the add or subtract, with its real operand order, overflows as a signed 32-bit operation; both move opcodes leave V unchanged.
- R10: Any opcode other than 0x2, 0x3, 0x4, 0x5, 0x7, 0xD, 0xF registers result 0 with write-enable 0 and leaves all flags unchanged, whatever set-flags is.
- R11: Result, write-enable and flags change one clock after the inputs are sampled; synchronous reset clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (shifted register or immediate) |
| shift_carry | input | 1 | Carry-out of the external shifter |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Update flags when 1 |
| result_q | output | 32 | Registered destination value |
| wr_en_q | output | 1 | Registered destination write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest cases to reach are the carry-consuming operations with a known carry flag: the flag is internal state, so the stimulus first runs an operation with set-flags high whose carry outcome is chosen (for example an add of all-ones plus one, or a subtract that borrows), then issues the add-with-carry or reverse-subtract-with-carry opcode. Signed overflow under reverse subtraction needs operands whose order matters, such as the most negative value minus one, and the unchanged-overflow rule for moves needs V forced to 1 just before the move. A long random run mixes legal and illegal opcodes with set-flags toggled so that held and updated flags chain across many operations.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_SUB = 4'h2,
    OP_RSB = 4'h3,
    OP_ADD = 4'h4,
    OP_ADC = 4'h5,
    OP_RSC = 4'h7,
    OP_MOV = 4'hD,
    OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic     legal;
    logic     is_move;
    logic     move_inv;
    logic     swap;
    logic     inv_y;
    cin_sel_e cin_sel;
  } alu_ctl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_code,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    ctl.cin_sel = CI_ZERO;
    case (op_code)
      OP_MOV: begin
        ctl.legal   = 1'b1;
        ctl.is_move = 1'b1;
      end
      OP_MVN: begin
        ctl.legal    = 1'b1;
        ctl.is_move  = 1'b1;
        ctl.move_inv = 1'b1;
      end
      OP_ADD: begin
        ctl.legal = 1'b1;
      end
      OP_ADC: begin
        ctl.legal   = 1'b1;
        ctl.cin_sel = CI_FLAG;
      end
      OP_SUB: begin
        ctl.legal   = 1'b1;
        ctl.inv_y   = 1'b1;
        ctl.cin_sel = CI_ONE;
      end
      OP_RSB: begin
        ctl.legal   = 1'b1;
        ctl.swap    = 1'b1;
        ctl.inv_y   = 1'b1;
        ctl.cin_sel = CI_ONE;
      end
      OP_RSC: begin
        ctl.legal   = 1'b1;
        ctl.swap    = 1'b1;
        ctl.inv_y   = 1'b1;
        ctl.cin_sel = CI_FLAG;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int WIDTH = 32,
  parameter int BLK   = 8,
  parameter bit CSEL  = 1'b1
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NBLK = WIDTH / BLK;

  generate
    if (!CSEL) begin : g_plain
      logic [WIDTH:0] full;
      assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
      assign sum  = full[WIDTH-1:0];
      assign cout = full[WIDTH];
    end else begin : g_csel
      logic [NBLK:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < NBLK; i++) begin : g_blk
        logic [BLK:0] s0;
        logic [BLK:0] s1;
        assign s0 = {1'b0, x[i*BLK +: BLK]} + {1'b0, y[i*BLK +: BLK]};
        assign s1 = {1'b0, x[i*BLK +: BLK]} + {1'b0, y[i*BLK +: BLK]}
                    + {{BLK{1'b0}}, 1'b1};
        assign sum[i*BLK +: BLK] = chain[i] ? s1[BLK-1:0] : s0[BLK-1:0];
        assign chain[i+1]        = chain[i] ? s1[BLK] : s0[BLK];
      end
      assign cout = chain[NBLK];
    end
  endgenerate

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             update,
  input  logic             is_move,
  input  logic             shift_carry,
  input  logic [WIDTH-1:0] result,
  input  logic             cout,
  input  logic             ovf,
  output alu_flags_t       flags_q
);

  alu_flags_t flags_d;

  always_comb begin
    flags_d   = flags_q;
    flags_d.n = result[WIDTH-1];
    flags_d.z = ~|result;
    flags_d.c = is_move ? shift_carry : cout;
    flags_d.v = is_move ? flags_q.v : ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (update) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BLK   = 8,
  parameter bit CSEL  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             shift_carry,
  input  logic [3:0]       op_code,
  input  logic             set_flags,
  output logic [WIDTH-1:0] result_q,
  output logic             wr_en_q,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int MSB = WIDTH - 1;

  alu_ctl_t   ctl;
  alu_flags_t flags_q;
  logic [WIDTH-1:0] x_opd, y_raw, y_opd, sum, move_val, result_d;
  logic cin, cout, ovf;

  dp_alu_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  assign x_opd = ctl.swap ? op_b : op_a;
  assign y_raw = ctl.swap ? op_a : op_b;
  assign y_opd = ctl.inv_y ? ~y_raw : y_raw;

  always_comb begin
    case (ctl.cin_sel)
      CI_ONE:  cin = 1'b1;
      CI_FLAG: cin = flags_q.c;
      default: cin = 1'b0;
    endcase
  end

  dp_alu_adder #(
    .WIDTH (WIDTH),
    .BLK   (BLK),
    .CSEL  (CSEL)
  ) u_add (
    .x    (x_opd),
    .y    (y_opd),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  assign ovf      = (x_opd[MSB] == y_opd[MSB]) && (sum[MSB] != x_opd[MSB]);
  assign move_val = ctl.move_inv ? ~op_b : op_b;

  always_comb begin
    if (!ctl.legal)      result_d = '0;
    else if (ctl.is_move) result_d = move_val;
    else                 result_d = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      wr_en_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      wr_en_q  <= ctl.legal;
    end
  end

  dp_alu_flags #(
    .WIDTH (WIDTH)
  ) u_flags (
    .clk         (clk),
    .rst         (rst),
    .update      (set_flags & ctl.legal),
    .is_move     (ctl.is_move),
    .shift_carry (shift_carry),
    .result      (result_d),
    .cout        (cout),
    .ovf         (ovf),
    .flags_q     (flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/dp_alu_unit_chk.sv
module dp_alu_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       op_code,
  input logic             set_flags,
  input logic [WIDTH-1:0] result_q,
  input logic             wr_en_q,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);

  logic known_op;
  assign known_op = (op_code == 4'h2) || (op_code == 4'h3) || (op_code == 4'h4) ||
                    (op_code == 4'h5) || (op_code == 4'h7) || (op_code == 4'hD) ||
                    (op_code == 4'hF);

  AST_MOVE_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'hD) |=> (result_q == $past(op_b)) && wr_en_q); // R1

  AST_MOVE_INV: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'hF) |=> (result_q == ~$past(op_b)) && wr_en_q); // R2

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R6

  AST_N_Z_TRACK: assert property (@(posedge clk) disable iff (rst)
    (set_flags && known_op) |=> (flag_n == result_q[WIDTH-1]) && (flag_z == (result_q == '0))); // R7

  AST_MOVE_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    ((op_code == 4'hD) || (op_code == 4'hF)) |=> $stable(flag_v)); // R9

  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    !known_op |=> !wr_en_q && (result_q == '0) && $stable({flag_n, flag_z, flag_c, flag_v})); // R10

endmodule

bind dp_alu_unit dp_alu_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_b      (op_b),
  .op_code   (op_code),
  .set_flags (set_flags),
  .result_q  (result_q),
  .wr_en_q   (wr_en_q),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v)
);

// File: tb/tb_dp_alu_unit.sv
module tb_dp_alu_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic        shift_carry = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic        set_flags = 1'b0;
  logic [31:0] result_q;
  logic        wr_en_q, flag_n, flag_z, flag_c, flag_v;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t sb[$];

  logic m_n = 0, m_z = 0, m_c = 0, m_v = 0;

  always #5 clk = ~clk;

  dp_alu_unit dut (
    .clk (clk), .rst (rst), .op_a (op_a), .op_b (op_b),
    .shift_carry (shift_carry), .op_code (op_code), .set_flags (set_flags),
    .result_q (result_q), .wr_en_q (wr_en_q),
    .flag_n (flag_n), .flag_z (flag_z), .flag_c (flag_c), .flag_v (flag_v)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sc,
                       input logic [3:0] op, input logic sf, input string tag);
    exp_t e;
    logic [32:0] full;
    longint sa, sb_v, sr;
    logic legal, nc, nv;
    logic [31:0] res;
    sa = $signed(a);
    sb_v = $signed(b);
    legal = 1'b1;
    nc = m_c;
    nv = m_v;
    res = '0;
    sr = 0;
    case (op)
      4'hD: begin res = b; nc = sc; end                     // R1
      4'hF: begin res = ~b; nc = sc; end                    // R2
      4'h4: begin full = {1'b0, a} + {1'b0, b}; sr = sa + sb_v; end
      4'h5: begin full = {1'b0, a} + {1'b0, b} + {32'd0, m_c}; sr = sa + sb_v + longint'(m_c); end
      4'h2: begin full = {1'b0, a} - {1'b0, b}; sr = sa - sb_v; end
      4'h3: begin full = {1'b0, b} - {1'b0, a}; sr = sb_v - sa; end
      4'h7: begin full = {1'b0, b} - {1'b0, a} - {32'd0, ~m_c}; sr = sb_v - sa - longint'(~m_c); end
      default: legal = 1'b0;
    endcase
    if (legal && op != 4'hD && op != 4'hF) begin
      res = full[31:0];
      if (op == 4'h4 || op == 4'h5) nc = full[32];
      else nc = ~full[32];
      nv = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end
    if (legal && sf) begin
      m_n = res[31];
      m_z = (res == 32'd0);
      m_c = nc;
      m_v = nv;
    end
    e.res = res;
    e.we  = legal;
    e.fl  = {m_n, m_z, m_c, m_v};
    e.tag = tag;
    @(negedge clk);
    op_a = a; op_b = b; shift_carry = sc; op_code = op; set_flags = sf;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " result"}, result_q, e.res);
        check({e.tag, " wr_en"}, {31'd0, wr_en_q}, {31'd0, e.we});
        check({e.tag, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, e.fl});
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset result", result_q, 32'd0);
    check("R11 reset flags", {27'd0, wr_en_q, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    rst = 1'b0;

    drive(32'h1, 32'hA5A5_0001, 1'b1, 4'hD, 1'b1, "R1 R8 mov");
    drive(32'h0, 32'h0, 1'b0, 4'hF, 1'b1, "R2 R7 mvn zero");
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, 4'h4, 1'b1, "R3 R7 R8 add wrap");
    drive(32'h10, 32'h20, 1'b0, 4'h5, 1'b1, "R3 adc c1");
    drive(32'h10, 32'h20, 1'b0, 4'h5, 1'b1, "R3 adc c0");
    drive(32'h7FFF_FFFF, 32'h1, 1'b0, 4'h4, 1'b1, "R9 add ovf");
    drive(32'h5, 32'h7, 1'b1, 4'hD, 1'b1, "R9 mov keeps V");
    drive(32'h5, 32'h7, 1'b0, 4'h2, 1'b1, "R4 R8 sub borrow");
    drive(32'h7, 32'h5, 1'b0, 4'h2, 1'b1, "R4 R8 sub no borrow");
    drive(32'h7, 32'h5, 1'b0, 4'h3, 1'b1, "R4 rsb neg");
    drive(32'h1, 32'h8000_0000, 1'b0, 4'h3, 1'b1, "R9 rsb ovf");
    drive(32'h3, 32'h9, 1'b0, 4'h3, 1'b1, "R4 rsb sets C");
    drive(32'h3, 32'h9, 1'b0, 4'h7, 1'b1, "R5 rsc c1");
    drive(32'h9, 32'h3, 1'b0, 4'h7, 1'b1, "R5 rsc borrow");
    drive(32'h3, 32'h9, 1'b0, 4'h7, 1'b1, "R5 rsc c0");
    drive(32'h0, 32'h0, 1'b1, 4'h4, 1'b0, "R6 add no flags");
    drive(32'h1234, 32'h5678, 1'b1, 4'h0, 1'b1, "R10 op0");
    drive(32'h1234, 32'h5678, 1'b1, 4'hE, 1'b1, "R10 opE");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, 4'h4, 1'b1, "R9 R8 add neg ovf");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      a = $urandom();
      b = $urandom();
      if (i % 5 == 0) b = a;
      if (i % 7 == 0) a = 32'h8000_0000;
      drive(a, b, 1'($urandom_range(0, 1)), op, 1'($urandom_range(0, 1)), "R3 R4 R5 R6 R8 R9 R10 random");
    end

    drive(32'h0, 32'h0, 1'b0, 4'h0, 1'b0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule